// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregation Controller

This block gathers one-cycle event pulses from four doorbell sources, eight DMA-channel sources and one error source into a latched cause register. An enable mask gates the latched causes. A bank of per-vector routing masks then decides which message-vector request outputs each enabled source raises. In legacy mode the block instead drives a single level-sensitive interrupt line.

Software reaches all state through a simple word-addressed 32-bit register port. Writes take effect on the clock edge, and read data is combinational from the address. The word addresses are: 0 cause, 1 enable, 2 enable-clear, 3 auto-clear mask, 4 mode, and 32+v the routing mask of vector v.

In multi-vector mode, a vector request can also clear the cause bits of the sources it carries, if those sources are marked for auto-clear.

Top module: `intr_aggregator`

## Requirements
- R1: Source n occupies bit n of the cause, enable, auto-clear and routing registers. Doorbell d is bit d (0..3), DMA channel c is bit 8+c (c = 0..7) and the error source is bit 30. Every other bit of these registers reads 0.
- R2: A source event sets its cause bit on the next edge. Writing 1 to a cause bit (address 0) clears it, writing 0 leaves it as it is, and a read of address 0 returns the latched causes.
- R3: If a source event and a write of 1 to the same cause bit arrive in the same cycle, the bit stays set.
- R4: The enable register (address 1) is read/write and keeps the written implemented bits.
- R5: A write to the enable-clear address 2 clears every enable bit written as 1 and leaves the others. Address 2 reads as 0.
- R6: The routing mask of vector v (address 32+v, v < 32) is read/write. Bit n set routes source n to vector v, and one source may be routed to several vectors.
- R7: When the mode field is not 0, a source whose cause AND enable turns from 0 to 1 marks every vector that routes it as pending. A pending vector raises its request output for exactly one cycle; the earliest such pulse comes one cycle after the cause bit is set.
- R8: At most one vector request is high in a cycle, and among pending vectors the lowest index goes first.
- R9: Mode field (address 4, bits 1:0): 0 legacy, 1 single-vector, 2 or 3 multi-vector. Only in multi-vector mode does a vector request clear the cause bits of the auto-clear mask (address 3) that its routing mask selects. Single-vector and legacy modes never auto-clear.
- R10: In mode 0 the legacy line equals the OR of cause AND enable, and it stays high until software clears those causes. No vector request is raised in mode 0.
- R11: After reset all registers read 0, the mode is legacy, and no output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| src_db | input | 4 | Doorbell event pulses |
| src_dma | input | 8 | DMA-channel event pulses |
| src_err | input | 1 | Error event pulse |
| vec_req | output | 32 | One-cycle vector request pulses |
| irq_level | output | 1 | Legacy interrupt level |

## Verification
The bench targets an event that collides with a write-1-to-clear of the same bit: a design that lets the clear win loses an interrupt for good. It routes one source to two vectors and checks that they fire on consecutive cycles in ascending order; merging or reordering them would show up as a wrong or double-hot request vector. It runs the same source under single-vector and multi-vector modes to confirm that auto-clear happens only in the latter. A design that ignored the mode there would silently drop causes that legacy software still expects to read. Long random traffic also covers enable-clear write-back and reserved-bit masking.

// File: rtl/intr_pkg.sv
// Shared constants for the interrupt aggregation controller: the source bit
// layout, the register word addresses and the mode encoding.
package intr_pkg;
    localparam int REG_W   = 32;
    localparam int DB_LSB  = 0;
    localparam int DB_N    = 4;
    localparam int DMA_LSB = 8;
    localparam int DMA_N   = 8;
    localparam int ERR_BIT = 30;

    localparam int A_CAUSE = 0;
    localparam int A_EN    = 1;
    localparam int A_ENCLR = 2;
    localparam int A_AC    = 3;
    localparam int A_MODE  = 4;
    localparam int A_MAP   = 32;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_MULTI  = 2'd2,
        MODE_MULTI3 = 2'd3
    } mode_e;

    // Mask of the implemented source bits
    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < DB_N; i++)  m[DB_LSB + i]  = 1'b1;
        for (int i = 0; i < DMA_N; i++) m[DMA_LSB + i] = 1'b1;
        m[ERR_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/intr_cause_reg.sv
// Latched cause register. Events set bits; software write-1-to-clear and
// vector auto-clear reset them, and a new event wins over both.
// Assumes ev, w1c and auto_clr only carry implemented bits.
module intr_cause_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] w1c,
    input  logic [W-1:0] auto_clr,
    output logic [W-1:0] cause
);
    // Cause update: clears first, then events override
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= ((cause & ~w1c & ~auto_clr) | ev) & MASK;
    end

    // R3
    ev_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((cause & $past(ev)) == $past(ev)));
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & ~MASK) == '0);
    // R2
    no_spont_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c == '0 && auto_clr == '0) |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/intr_vec_arb.sv
// Vector routing and arbitration. It detects newly active sources, marks
// each vector that routes them as pending and grants the lowest pending
// vector each cycle. In multi-vector mode it returns the cause bits to
// auto-clear. Assumes active = cause AND enable, taken from registers.
module intr_vec_arb #(
    parameter int NUM_VEC = 32,
    parameter int W       = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         active,
    input  logic                 vec_on,
    input  logic                 multi,
    input  logic [NUM_VEC*W-1:0] map_flat,
    input  logic [W-1:0]         ac_mask,
    output logic [NUM_VEC-1:0]   vec_req,
    output logic [W-1:0]         auto_clr
);
    logic [W-1:0]       active_q;
    logic [W-1:0]       rise;
    logic [NUM_VEC-1:0] hits;
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] grant;
    logic [W-1:0]       clr_acc;

    assign rise = active & ~active_q;

    // Per-vector hit on a newly active routed source
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_hit
        assign hits[v] = vec_on & (|(rise & map_flat[v*W +: W]));
    end

    // Lowest-index grant among pending vectors
    assign grant   = vec_on ? (pend & (~pend + 1'b1)) : '0;
    assign vec_req = grant;

    // Collect routing masks of the granted vector
    always_comb begin
        clr_acc = '0;
        for (int v = 0; v < NUM_VEC; v++)
            if (grant[v]) clr_acc = clr_acc | map_flat[v*W +: W];
    end
    assign auto_clr = multi ? (clr_acc & ac_mask) : '0;

    // Edge history and pending vector state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            pend     <= '0;
        end else begin
            active_q <= active;
            pend     <= (pend & ~grant) | hits;
        end
    end

    // R8
    vec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_req));
    // R8
    grant_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req != '0) |-> ((vec_req & pend) == vec_req));
    // R9
    ac_only_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !multi |-> (auto_clr == '0));
endmodule

// File: rtl/intr_aggregator.sv
// Interrupt aggregation controller top. It holds the software registers
// (enable, auto-clear mask, mode, routing masks), assembles the source
// events, and drives the vector requests and the legacy level.
// Assumes NUM_VEC is between 4 and 32 so the routing masks fit the map window.
module intr_aggregator
    import intr_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [DB_N-1:0]    src_db,
    input  logic [DMA_N-1:0]   src_dma,
    input  logic               src_err,
    output logic [NUM_VEC-1:0] vec_req,
    output logic               irq_level
);
    localparam logic [REG_W-1:0] MASK = src_mask();
    localparam int VIW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [REG_W-1:0]         ev, cause, en_q, ac_q, w1c, auto_clr, active;
    logic [REG_W-1:0]         map_q [NUM_VEC];
    logic [NUM_VEC*REG_W-1:0] map_flat;
    mode_e                    mode_q;
    logic                     map_hit;
    logic [ADDR_W-1:0]        map_off;
    logic                     vec_on, multi;

    // Place the source pulses on their register bit positions
    always_comb begin
        ev = '0;
        ev[DB_LSB +: DB_N]   = src_db;
        ev[DMA_LSB +: DMA_N] = src_dma;
        ev[ERR_BIT]          = src_err;
    end

    assign w1c     = (reg_wr_en && reg_addr == ADDR_W'(A_CAUSE)) ? (reg_wdata & MASK) : '0;
    assign active  = cause & en_q;
    assign vec_on  = (mode_q != MODE_LEGACY);
    assign multi   = mode_q[1];
    assign map_off = reg_addr - ADDR_W'(A_MAP);
    assign map_hit = (reg_addr >= ADDR_W'(A_MAP)) && (map_off < ADDR_W'(NUM_VEC));

    // Enable, auto-clear mask and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ac_q   <= '0;
            mode_q <= MODE_LEGACY;
        end else if (reg_wr_en) begin
            if (reg_addr == ADDR_W'(A_EN))    en_q   <= reg_wdata & MASK;
            if (reg_addr == ADDR_W'(A_ENCLR)) en_q   <= en_q & ~reg_wdata;
            if (reg_addr == ADDR_W'(A_AC))    ac_q   <= reg_wdata & MASK;
            if (reg_addr == ADDR_W'(A_MODE))  mode_q <= mode_e'(reg_wdata[1:0]);
        end
    end

    // One routing mask register per vector
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[v] <= '0;
            else if (reg_wr_en && map_hit && map_off[VIW-1:0] == VIW'(v))
                map_q[v] <= reg_wdata & MASK;
        end
        assign map_flat[v*REG_W +: REG_W] = map_q[v];
    end

    // Read data selection
    always_comb begin
        reg_rdata = '0;
        if (map_hit) reg_rdata = map_q[map_off[VIW-1:0]];
        else case (reg_addr)
            ADDR_W'(A_CAUSE): reg_rdata = cause;
            ADDR_W'(A_EN):    reg_rdata = en_q;
            ADDR_W'(A_AC):    reg_rdata = ac_q;
            ADDR_W'(A_MODE):  reg_rdata = {{(REG_W-2){1'b0}}, mode_q};
            default:          reg_rdata = '0;
        endcase
    end

    assign irq_level = (mode_q == MODE_LEGACY) && (|active);

    intr_cause_reg #(.W(REG_W), .MASK(MASK)) cause_i (
        .clk(clk), .rst_n(rst_n), .ev(ev & MASK), .w1c(w1c),
        .auto_clr(auto_clr), .cause(cause)
    );

    intr_vec_arb #(.NUM_VEC(NUM_VEC), .W(REG_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .active(active), .vec_on(vec_on),
        .multi(multi), .map_flat(map_flat), .ac_mask(ac_q),
        .vec_req(vec_req), .auto_clr(auto_clr)
    );

    // R10
    legacy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> (vec_req == '0));
    // R5
    enclr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(A_ENCLR)) |=> ((en_q & $past(reg_wdata)) == '0));
endmodule

// File: tb/intr_aggregator_tb.sv
// Bench: directed corner cases, then fixed-seed random traffic checked
// every cycle against a cycle model built from the requirements.
module intr_aggregator_tb_top;
    localparam logic [31:0] MASK = 32'h4000_FF0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_db = '0;
    logic [7:0]  src_dma = '0;
    logic        src_err = 1'b0;
    logic [31:0] vec_req;
    logic        irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    intr_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_db(src_db),
        .src_dma(src_dma), .src_err(src_err), .vec_req(vec_req),
        .irq_level(irq_level)
    );

    // Reference state
    logic [31:0] m_cause, m_en, m_ac, m_actq, m_pend;
    logic [1:0]  m_mode;
    logic [31:0] m_map [32];

    function automatic logic [31:0] lowest(input logic [31:0] x);
        for (int i = 0; i < 32; i++) if (x[i]) return 32'd1 << i;
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_vec();
        return (m_mode != 2'd0) ? lowest(m_pend) : 32'd0;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        if (a >= 6'd32) return m_map[a - 6'd32];
        case (a)
            6'd0: return m_cause;
            6'd1: return m_en;
            6'd3: return m_ac;
            6'd4: return {30'd0, m_mode};
            default: return 32'd0;
        endcase
    endfunction

    // Reference model update at each edge
    always @(posedge clk) begin
        logic [31:0] ev, act, rise, g, clr, w1c, hits;
        if (!rst_n) begin
            m_cause = 0; m_en = 0; m_ac = 0; m_actq = 0; m_pend = 0; m_mode = 0;
            for (int i = 0; i < 32; i++) m_map[i] = 0;
        end else begin
            ev = {1'b0, src_err, 14'd0, src_dma, 4'd0, src_db};
            act = m_cause & m_en;
            rise = act & ~m_actq;
            hits = 0;
            for (int v = 0; v < 32; v++)
                if (m_mode != 0 && (rise & m_map[v]) != 0) hits[v] = 1'b1;
            g = exp_vec();
            clr = 0;
            for (int v = 0; v < 32; v++) if (g[v]) clr = m_map[v] & m_ac;
            if (!m_mode[1]) clr = 0;
            w1c = (reg_wr_en && reg_addr == 0) ? reg_wdata : 0;
            m_cause = ((m_cause & ~w1c & ~clr) | ev) & MASK;
            m_actq = act;
            m_pend = (m_pend & ~g) | hits;
            if (reg_wr_en) begin
                if (reg_addr == 1) m_en = reg_wdata & MASK;
                if (reg_addr == 2) m_en = m_en & ~reg_wdata;
                if (reg_addr == 3) m_ac = reg_wdata & MASK;
                if (reg_addr == 4) m_mode = reg_wdata[1:0];
                if (reg_addr >= 32) m_map[reg_addr - 6'd32] = reg_wdata & MASK;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 R8 vector requests", vec_req, exp_vec());
            check("R10 legacy level", {31'd0, irq_level},
                  {31'd0, (m_mode == 0) && ((m_cause & m_en) != 0)});
            check("R2 R6 register read", reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] db, input logic [7:0] dma, input logic er);
        @(posedge clk); #1;
        src_db = db; src_dma = dma; src_err = er;
        @(posedge clk); #1;
        src_db = 0; src_dma = 0; src_err = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 reset state
        rd(0, d); check("R11 cause after reset", d, 0);
        rd(1, d); check("R11 enable after reset", d, 0);
        rd(4, d); check("R11 mode after reset", d, 0);
        rd(32, d); check("R11 map0 after reset", d, 0);
        check("R11 legacy line after reset", {31'd0, irq_level}, 0);

        // R1 bit layout, R4 enable, R10 level
        pulse(4'hF, 8'hFF, 1'b1);
        rd(0, d); check("R1 cause layout", d, 32'h4000_FF0F);
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); check("R4 enable readback", d, 32'h4000_FF0F);
        check("R10 level with enabled causes", {31'd0, irq_level}, 1);

        // R2 write one clears, write zero holds
        wr(0, 32'h1);
        rd(0, d); check("R2 w1c bit0", d, 32'h4000_FF0E);
        wr(0, 32'h0);
        rd(0, d); check("R2 write zero holds", d, 32'h4000_FF0E);

        // R3 event collides with w1c on bit1
        @(posedge clk); #1;
        reg_wr_en = 1; reg_addr = 0; reg_wdata = 32'h2; src_db = 4'h2;
        @(posedge clk); #1;
        reg_wr_en = 0; src_db = 0;
        rd(0, d); check("R3 event wins over clear", d & 32'h2, 32'h2);

        // R5 enable-clear with write-back of the current enable
        wr(2, 32'h4000_FF0F);
        rd(1, d); check("R5 enable cleared", d, 0);
        rd(2, d); check("R5 enable-clear reads zero", d, 0);
        check("R10 level drops when disabled", {31'd0, irq_level}, 0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); check("R2 clear all", d, 0);

        // R6 R8 one source on two vectors, single-vector mode
        wr(4, 1);
        wr(34, 32'h1);
        wr(37, 32'h101);
        rd(37, d); check("R6 map readback", d, 32'h101);
        wr(1, 32'h101);
        wr(3, 32'h1);
        pulse(4'h1, 0, 0);
        @(negedge clk); check("R7 no request yet", vec_req, 0);
        @(negedge clk); check("R8 lower vector first", vec_req, 32'h4);
        @(negedge clk); check("R8 second vector next", vec_req, 32'h20);
        @(negedge clk); check("R7 pulse ends", vec_req, 0);
        rd(0, d); check("R9 no auto-clear in single mode", d, 32'h1);

        // R9 multi-vector auto-clear
        wr(0, 32'hFFFF_FFFF);
        wr(4, 2);
        pulse(4'h1, 8'h01, 0);
        idle(5);
        rd(0, d); check("R9 auto-clear only masked source", d, 32'h100);
        wr(0, 32'hFFFF_FFFF);

        // Random traffic, model compared every cycle
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #1;
            reg_wr_en = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 6))
                0: reg_addr = 0;
                1: reg_addr = 1;
                2: reg_addr = 2;
                3: reg_addr = 3;
                4: reg_addr = ($urandom_range(0, 7) == 0) ? 6'd4 : 6'd5;
                default: reg_addr = 6'd32 + 6'($urandom_range(0, 7));
            endcase
            reg_wdata = $urandom;
            if (reg_addr == 0) reg_wdata = reg_wdata & $urandom;
            src_db  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            src_dma = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
            src_err = ($urandom_range(0, 15) == 0);
        end
        @(posedge clk); #1;
        reg_wr_en = 0; src_db = 0; src_dma = 0; src_err = 0;
        idle(4);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule